// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit with Overflow Flags

This block multiplies two 32-bit operands, either both signed or both unsigned, and can add a 64-bit accumulator pair to the product. A start strobe loads the operands, the accumulator words, the signedness select and the accumulate enable. The unit then works through the multiplier operand eight bits per cycle and stops as soon as the bits it has not yet used carry no further information. When it finishes it raises a one-cycle done strobe and presents the 64-bit result as a low word and a high word.

Two overflow flags are produced with every result. The narrow flag reports that the result does not fit in 32 bits. For unsigned operations this means the high word is nonzero. For signed operations it means the high word is not the sign extension of the low word. The accumulate flag reports that the 64-bit addition left the 64-bit range: the final carry for unsigned operations, and the two's-complement overflow of the high-word addition for signed ones. A software routine that needs a 32-bit result or a bounded 64-bit sum reads these flags and needs no compare instructions after the operation.

Top module: `mac_unit`

## Requirements
- R1: With op_signed low, {res_hi, res_lo} equals the unsigned product of mul_a and mul_b, modulo 2^64, when acc_en was low at start.
- R2: With op_signed high, {res_hi, res_lo} equals the two's-complement product of mul_a and mul_b as a 64-bit value, when acc_en was low at start.
- R3: With acc_en high at start, the result is the product plus {acc_hi, acc_lo}, modulo 2^64. The low words are added first and their carry enters the high-word addition.
- R4: For an unsigned operation, ovf_narrow is 1 exactly when res_hi is nonzero.
- R5: For a signed operation, ovf_narrow is 1 exactly when res_hi differs from bit 31 of res_lo copied into all 32 bits.
- R6: For an unsigned accumulate, ovf_acc equals the carry out of the high-word addition.
- R7: For a signed accumulate, ovf_acc is 1 exactly when the product high word and acc_hi have the same sign and the high word of the sum has the other sign.
- R8: When acc_en was low at start, ovf_acc reads 0.
- R9: Let n be the smallest k in 1..4 for which the multiplier bits above bit 8k-1 are all zero, or, for a signed operation, all one. For k = 4 this always holds. The cycle in which start is sampled counts as cycle 1, and done is high in cycle n+2 of a plain multiply, which is cycle 3 to cycle 6.
- R10: An accumulate takes one cycle more than a plain multiply with the same multiplier, so done is high in cycle n+3, which is cycle 4 to cycle 7.
- R11: done is high for exactly one cycle. The result words and both flags change only in the cycle in which done rises, and they hold their values until the next done.
- R12: A start that arrives while an operation is in progress is ignored. It changes neither that operation's result nor its timing, and it produces no extra done.
- R13: After reset, done, res_lo, res_hi, ovf_narrow and ovf_acc are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| op_signed | input | 1 | 1 = both operands two's complement, 0 = unsigned |
| acc_en | input | 1 | 1 = add {acc_hi, acc_lo} to the product |
| mul_a | input | 32 | Multiplicand |
| mul_b | input | 32 | Multiplier; its significant bytes set the latency |
| acc_lo | input | 32 | Accumulator low word |
| acc_hi | input | 32 | Accumulator high word |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word |
| ovf_narrow | output | 1 | Result does not fit in 32 bits |
| ovf_acc | output | 1 | 64-bit accumulate overflowed |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach is the signed early stop on a negative multiplier. Here the unit ends after one to three bytes and must subtract a shifted copy of the multiplicand to undo the unsigned weighting of the bytes it has already used. Uniform random multipliers almost always run the full four bytes. The stimulus therefore builds most multipliers by sign- or zero-extending a random 8-bit or 16-bit value, and it adds directed values such as -1 and 0x80000000. Accumulate overflow is rare with random values, so directed operand pairs drive the carry out and the signed overflow of the high-word addition in both directions.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_ACC  = 2'd2
    } mac_state_e;
endpackage

// File: rtl/mac_step.sv
// One radix-2^CHUNK iteration: adds the partial product of the lowest
// remaining multiplier byte, shifts both operands, and decides whether
// the remaining multiplier bits allow an early stop.
module mac_step #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned CHUNK = 8
) (
    input  logic [2*WIDTH-1:0] prod_i,
    input  logic [2*WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0]   mrem_i,
    input  logic               sgn_i,
    input  logic               last_i,
    output logic [2*WIDTH-1:0] prod_o,
    output logic [2*WIDTH-1:0] mcand_o,
    output logic [WIDTH-1:0]   mrem_o,
    output logic               finish_o
);
    localparam int unsigned PW = 2 * WIDTH;

    logic [PW-1:0]    chunk_ext;
    logic [PW-1:0]    partial;
    logic             rem_zero;
    logic             rem_ones;
    logic             correct;

    always_comb begin
        chunk_ext = PW'(mrem_i[CHUNK-1:0]);
        partial   = mcand_i * chunk_ext;
        mcand_o   = mcand_i << CHUNK;
        if (sgn_i) begin
            mrem_o = $unsigned($signed(mrem_i) >>> CHUNK);
        end else begin
            mrem_o = mrem_i >> CHUNK;
        end
        rem_zero = ~|mrem_o;
        rem_ones = &mrem_o;
        finish_o = last_i | rem_zero | (sgn_i & rem_ones);
        // a negative remainder of all ones weighs -1 at the next byte position
        correct  = sgn_i & rem_ones;
        prod_o   = prod_i + partial - (correct ? mcand_o : '0);
    end
endmodule

// File: rtl/mac_accum.sv
// 64-bit accumulate done as two word additions joined by the carry.
module mac_accum #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] prod_i,
    input  logic [WIDTH-1:0]   add_lo_i,
    input  logic [WIDTH-1:0]   add_hi_i,
    input  logic               sgn_i,
    output logic [2*WIDTH-1:0] sum_o,
    output logic               ovf_o
);
    logic [WIDTH:0] lo_sum;
    logic [WIDTH:0] hi_sum;
    logic [WIDTH-1:0] p_hi;

    always_comb begin
        p_hi   = prod_i[2*WIDTH-1:WIDTH];
        lo_sum = {1'b0, prod_i[WIDTH-1:0]} + {1'b0, add_lo_i};
        hi_sum = {1'b0, p_hi} + {1'b0, add_hi_i} + {{WIDTH{1'b0}}, lo_sum[WIDTH]};
        sum_o  = {hi_sum[WIDTH-1:0], lo_sum[WIDTH-1:0]};
        if (sgn_i) begin
            ovf_o = (p_hi[WIDTH-1] == add_hi_i[WIDTH-1]) &&
                    (hi_sum[WIDTH-1] != p_hi[WIDTH-1]);
        end else begin
            ovf_o = hi_sum[WIDTH];
        end
    end
endmodule

// File: rtl/mac_narrow.sv
// Does the double-width value fit in one word?
module mac_narrow #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] val_i,
    input  logic               sgn_i,
    output logic               ovf_o
);
    logic [WIDTH-1:0] hi_ref;

    always_comb begin
        hi_ref = sgn_i ? {WIDTH{val_i[WIDTH-1]}} : '0;
        ovf_o  = (val_i[2*WIDTH-1:WIDTH] != hi_ref);
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned CHUNK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_signed,
    input  logic             acc_en,
    input  logic [WIDTH-1:0] mul_a,
    input  logic [WIDTH-1:0] mul_b,
    input  logic [WIDTH-1:0] acc_lo,
    input  logic [WIDTH-1:0] acc_hi,
    output logic [WIDTH-1:0] res_lo,
    output logic [WIDTH-1:0] res_hi,
    output logic             ovf_narrow,
    output logic             ovf_acc,
    output logic             done
);
    import mac_pkg::*;

    localparam int unsigned PW     = 2 * WIDTH;
    localparam int unsigned NCHUNK = WIDTH / CHUNK;
    localparam int unsigned CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;

    typedef struct packed {
        mac_state_e       state;
        logic             sgn;
        logic             acc;
        logic [PW-1:0]    mcand;
        logic [WIDTH-1:0] mrem;
        logic [PW-1:0]    prod;
        logic [CW-1:0]    step;
        logic [WIDTH-1:0] add_lo;
        logic [WIDTH-1:0] add_hi;
        logic [PW-1:0]    res;
        logic             ovf_n;
        logic             ovf_a;
        logic             done;
    } mac_regs_t;

    mac_regs_t regs_d, regs_q;

    logic [PW-1:0]    prod_nxt;
    logic [PW-1:0]    mcand_nxt;
    logic [WIDTH-1:0] mrem_nxt;
    logic             step_finish;
    logic             step_last;
    logic [PW-1:0]    acc_sum;
    logic             acc_ovf;
    logic [PW-1:0]    narrow_in;
    logic             narrow_ovf;
    logic [PW-1:0]    mcand_load;

    assign step_last = (regs_q.step == CW'(NCHUNK - 1));

    mac_step #(.WIDTH(WIDTH), .CHUNK(CHUNK)) step_i (
        .prod_i   (regs_q.prod),
        .mcand_i  (regs_q.mcand),
        .mrem_i   (regs_q.mrem),
        .sgn_i    (regs_q.sgn),
        .last_i   (step_last),
        .prod_o   (prod_nxt),
        .mcand_o  (mcand_nxt),
        .mrem_o   (mrem_nxt),
        .finish_o (step_finish)
    );

    mac_accum #(.WIDTH(WIDTH)) accum_i (
        .prod_i   (regs_q.prod),
        .add_lo_i (regs_q.add_lo),
        .add_hi_i (regs_q.add_hi),
        .sgn_i    (regs_q.sgn),
        .sum_o    (acc_sum),
        .ovf_o    (acc_ovf)
    );

    assign narrow_in = (regs_q.state == ST_ACC) ? acc_sum : prod_nxt;

    mac_narrow #(.WIDTH(WIDTH)) narrow_i (
        .val_i (narrow_in),
        .sgn_i (regs_q.sgn),
        .ovf_o (narrow_ovf)
    );

    always_comb begin
        mcand_load = op_signed ? {{WIDTH{mul_a[WIDTH-1]}}, mul_a}
                               : {{WIDTH{1'b0}}, mul_a};
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (start) begin
                    regs_d.state  = ST_MUL;
                    regs_d.sgn    = op_signed;
                    regs_d.acc    = acc_en;
                    regs_d.mcand  = mcand_load;
                    regs_d.mrem   = mul_b;
                    regs_d.prod   = '0;
                    regs_d.step   = '0;
                    regs_d.add_lo = acc_lo;
                    regs_d.add_hi = acc_hi;
                end
            end
            ST_MUL: begin
                regs_d.prod  = prod_nxt;
                regs_d.mcand = mcand_nxt;
                regs_d.mrem  = mrem_nxt;
                regs_d.step  = regs_q.step + 1'b1;
                if (step_finish) begin
                    if (regs_q.acc) begin
                        regs_d.state = ST_ACC;
                    end else begin
                        regs_d.state = ST_IDLE;
                        regs_d.done  = 1'b1;
                        regs_d.res   = prod_nxt;
                        regs_d.ovf_n = narrow_ovf;
                        regs_d.ovf_a = 1'b0;
                    end
                end
            end
            ST_ACC: begin
                regs_d.state = ST_IDLE;
                regs_d.done  = 1'b1;
                regs_d.res   = acc_sum;
                regs_d.ovf_n = narrow_ovf;
                regs_d.ovf_a = acc_ovf;
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign res_lo     = regs_q.res[WIDTH-1:0];
    assign res_hi     = regs_q.res[PW-1:WIDTH];
    assign ovf_narrow = regs_q.ovf_n;
    assign ovf_acc    = regs_q.ovf_a;
    assign done       = regs_q.done;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned CHUNK = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             op_signed,
    input logic             acc_en,
    input logic [WIDTH-1:0] res_lo,
    input logic [WIDTH-1:0] res_hi,
    input logic             ovf_narrow,
    input logic             ovf_acc,
    input logic             done
);
    localparam int unsigned NCHUNK = WIDTH / CHUNK;

    logic       busy_c;
    logic       sgn_c;
    logic       acc_c;
    logic [7:0] cyc_c;
    logic       accept;

    assign accept = start && (!busy_c || done);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            sgn_c  <= 1'b0;
            acc_c  <= 1'b0;
            cyc_c  <= '0;
        end else if (accept) begin
            busy_c <= 1'b1;
            sgn_c  <= op_signed;
            acc_c  <= acc_en;
            cyc_c  <= 8'd2;
        end else if (done) begin
            busy_c <= 1'b0;
        end else if (busy_c && cyc_c != 8'hFF) begin
            cyc_c  <= cyc_c + 8'd1;
        end
    end

    p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sgn_c) |-> (ovf_narrow == (res_hi != '0)));

    p_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sgn_c) |-> (ovf_narrow == (res_hi != {WIDTH{res_lo[WIDTH-1]}})));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !acc_c) |-> !ovf_acc);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !acc_c) |-> (cyc_c >= 8'd3 && cyc_c <= 8'(NCHUNK + 2)));

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && acc_c) |-> (cyc_c >= 8'd4 && cyc_c <= 8'(NCHUNK + 3)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_lo) && $stable(res_hi) &&
                   $stable(ovf_narrow) && $stable(ovf_acc)));

    p_no_idle_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_c |-> !done);
endmodule

bind mac_unit mac_unit_chk #(.WIDTH(WIDTH), .CHUNK(CHUNK)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_signed  (op_signed),
    .acc_en     (acc_en),
    .res_lo     (res_lo),
    .res_hi     (res_hi),
    .ovf_narrow (ovf_narrow),
    .ovf_acc    (ovf_acc),
    .done       (done)
);

// File: tb/mac_unit_tb_top.sv
`timescale 1ns/1ps
module mac_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_signed = 1'b0;
    logic        acc_en = 1'b0;
    logic [31:0] mul_a = '0;
    logic [31:0] mul_b = '0;
    logic [31:0] acc_lo = '0;
    logic [31:0] acc_hi = '0;
    logic [31:0] res_lo;
    logic [31:0] res_hi;
    logic        ovf_narrow;
    logic        ovf_acc;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_signed(op_signed),
        .acc_en(acc_en), .mul_a(mul_a), .mul_b(mul_b), .acc_lo(acc_lo),
        .acc_hi(acc_hi), .res_lo(res_lo), .res_hi(res_hi),
        .ovf_narrow(ovf_narrow), .ovf_acc(ovf_acc), .done(done)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_chunks(input logic [31:0] b, input bit sgn);
        for (int k = 1; k <= 4; k++) begin
            logic [31:0] rem;
            rem = sgn ? $unsigned($signed(b) >>> (8 * k)) : (b >> (8 * k));
            if (k == 4 || rem == '0 || (sgn && rem == '1)) return k;
        end
        return 4;
    endfunction

    function automatic logic [63:0] exp_prod(input logic [31:0] a, b, input bit sgn);
        logic [63:0] ea, eb;
        ea = sgn ? {{32{a[31]}}, a} : {32'b0, a};
        eb = sgn ? {{32{b[31]}}, b} : {32'b0, b};
        return ea * eb;
    endfunction

    task automatic run_op(input logic [31:0] a, b, input bit sgn, acc,
                          input logic [31:0] alo, ahi);
        logic [63:0] p, r;
        logic [32:0] lo_s, hi_s;
        bit          exp_n, exp_a, got;
        int          cyc, exp_cyc;
        string       rq_res, rq_acc, rq_lat;
        p = exp_prod(a, b, sgn);
        if (acc) begin
            lo_s  = {1'b0, p[31:0]} + {1'b0, alo};
            hi_s  = {1'b0, p[63:32]} + {1'b0, ahi} + {32'b0, lo_s[32]};
            r     = {hi_s[31:0], lo_s[31:0]};
            exp_a = sgn ? ((p[63] == ahi[31]) && (hi_s[31] != p[63])) : hi_s[32];
        end else begin
            r     = p;
            exp_a = 1'b0;
        end
        exp_n   = sgn ? (r[63:32] != {32{r[31]}}) : (r[63:32] != 32'd0);
        exp_cyc = exp_chunks(b, sgn) + 2 + (acc ? 1 : 0);
        rq_res  = acc ? "R3" : (sgn ? "R2" : "R1");
        rq_acc  = acc ? (sgn ? "R7" : "R6") : "R8";
        rq_lat  = acc ? "R10" : "R9";

        @(negedge clk);
        mul_a = a; mul_b = b; op_signed = sgn; acc_en = acc;
        acc_lo = alo; acc_hi = ahi; start = 1'b1;
        cyc = 1; got = 1'b0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (done) got = 1'b1;
        end
        check(got, "R9 done seen", 64'(got), 64'd1);
        check(cyc == exp_cyc, rq_lat, 64'(cyc), 64'(exp_cyc));
        check({res_hi, res_lo} == r, rq_res, {res_hi, res_lo}, r);
        check(ovf_narrow == exp_n, sgn ? "R5" : "R4", 64'(ovf_narrow), 64'(exp_n));
        check(ovf_acc == exp_a, rq_acc, 64'(ovf_acc), 64'(exp_a));
        @(negedge clk);
        check(done == 1'b0, "R11 pulse", 64'(done), 64'd0);
    endtask

    initial begin
        logic [63:0] held;
        bit          extra;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check({res_hi, res_lo} == 64'd0, "R13 result", {res_hi, res_lo}, 64'd0);
        check({done, ovf_narrow, ovf_acc} == 3'b000, "R13 flags",
              64'({done, ovf_narrow, ovf_acc}), 64'd0);

        // directed corner cases
        run_op(32'd0, 32'd0, 1'b0, 1'b0, 32'd0, 32'd0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'd0, 32'd0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'd0, 32'd0);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 32'd0, 32'd0);
        run_op(32'h1234_5678, 32'hFFFF_FF80, 1'b1, 1'b0, 32'd0, 32'd0);
        run_op(32'h0000_0003, 32'h0000_0101, 1'b1, 1'b0, 32'd0, 32'd0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b1, 32'd0, 32'h7FFF_FFFF);
        run_op(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b1, 32'd0, 32'h8000_0000);
        run_op(32'd0, 32'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h7FFF_FFFF);

        // R11 hold while idle
        held = {res_hi, res_lo};
        repeat (4) @(negedge clk);
        check({res_hi, res_lo} == held, "R11 hold", {res_hi, res_lo}, held);

        // R12: start while busy is ignored
        @(negedge clk);
        mul_a = 32'h0001_0003; mul_b = 32'h1234_5678; op_signed = 1'b0;
        acc_en = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        mul_a = 32'd7; mul_b = 32'd9; acc_en = 1'b1; acc_lo = 32'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        // cycle 4 now; done expected in cycle 6
        @(negedge clk);
        check(done == 1'b0, "R12 timing early", 64'(done), 64'd0);
        @(negedge clk);
        check(done == 1'b1, "R12 timing", 64'(done), 64'd1);
        check({res_hi, res_lo} == exp_prod(32'h0001_0003, 32'h1234_5678, 1'b0),
              "R12 result", {res_hi, res_lo},
              exp_prod(32'h0001_0003, 32'h1234_5678, 1'b0));
        extra = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done) extra = 1'b1;
        end
        check(extra == 1'b0, "R12 no extra done", 64'(extra), 64'd0);

        // constrained random
        for (int t = 0; t < 400; t++) begin
            logic [31:0] a, b, alo, ahi;
            bit          sg, ac;
            a = $urandom; b = $urandom; alo = $urandom; ahi = $urandom;
            sg = 1'($urandom); ac = 1'($urandom);
            case ($urandom % 5)
                0: b = {{24{b[7]}}, b[7:0]};
                1: b = {{16{b[15]}}, b[15:0]};
                2: b = {24'd0, b[7:0]};
                3: b = {{8{b[23]}}, b[23:0]};
                default: ;
            endcase
            if (($urandom % 4) == 0) a = {{16{a[15]}}, a[15:0]};
            run_op(a, b, sg, ac, alo, ahi);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #3000000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule